// File: doc/BRIEF.md
# Truncated Signed Approximate Multiplier

This block multiplies two N-bit two's-complement operands and returns an approximate 2N-bit two's-complement product, with no clock. Sign handling follows the Baugh-Wooley scheme. Partial products that pair exactly one sign bit with an ordinary bit are inverted. Constant ones are added to correct for that inversion. The columns below weight 2^(N-1) are never built. A fixed compensation term at column N-1 replaces their average contribution.

The constant ones are not carried on wires. Two small compressor types absorb them. One adds three ordinary bits plus an implicit one. The other adds four ordinary bits plus an implicit one. The rest of the matrix goes through a linear carry-save row chain. A ripple-carry adder then resolves the result. The block suits error-tolerant datapaths such as image filtering kernels, which accept a small bounded error in exchange for fewer adder cells.

Top module: `sfc_mult`

## Requirements
- R1: Operands are N-bit two's complement (N = 8 by default). The product is 2N-bit two's complement and does not wrap at the extreme pairs: at N=8, -128 x -128 gives 16640 and -128 x 127 gives -16000.
- R2: Product bits 0 to N-2 are zero for every operand pair.
- R3: The three-input compressor outputs a sum of weight 1 and two carries of weight 2 each. For all 8 input combinations, sum + 2*(carry1 + carry2) equals x0 + x1 + x2 + 1.
- R4: The four-input compressor has the same outputs and weights. For all 16 input combinations, sum + 2*(carry1 + carry2) equals x0 + x1 + x2 + x3 + 1.
- R5: The product equals exact - T + K, where:
  - T is the sum of a[i]*b[j]*2^(i+j) over all pairs with i+j <= N-2.
  - K = C*2^(N-1), and C is the mean of T over uniform operands (sum over k<=N-2 of (k+1)*2^k/4) divided by 2^(N-1) and rounded to the nearest integer.
  - At N=8, C = 2 and K = 256.
- R6: |product - exact| <= max(K, Tmax - K), where Tmax = (N-2)*2^(N-1) + 1. At N=8 the bound is 513, and 127 x 127 reaches it with a product of 15616.
- R7: With both operands zero, the product equals K (256 at N=8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| prod | output | 2N | Approximate product, two's complement |

## Verification
Assertions placed in the compressor, carry-save and final-adder modules check on every evaluation that no reduction step gains or loses weight:
- each compressor's outputs count its inputs plus the absorbed one;
- each carry-save row keeps the three-row total;
- the ripple adder equals the sum of its two rows.

These checks cannot show that the right bits were routed into the compressors, that the truncation boundary is in the right column, or that the compensation has the right value. Only the bench's end-to-end comparisons show those:
- the exhaustive sweep of operand pairs against the exact-minus-truncated-plus-K formula;
- the zero-operand case;
- the extreme sign cases;
- the pair that reaches the worst-case error.

// File: rtl/sfc_mult_pkg.sv
package sfc_mult_pkg;

    // Outputs of a constant-absorbing compressor: sum weight 1, carries weight 2.
    typedef struct packed {
        logic carry2;
        logic carry1;
        logic sum;
    } sfc_out_t;

    // Compensation in units of 2^(n-1): rounded mean of the dropped columns.
    function automatic int comp_units(input int n);
        return (((n - 2) << (n - 1)) + 1 + (1 << n)) >> (n + 1);
    endfunction

endpackage

// File: rtl/sfc_ppgen.sv
module sfc_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0]                a_in,
    input  logic [N-1:0]                b_in,
    output logic [N-1:0][2*N-1:0]       pp
);
    localparam int W = 2 * N;

    // Row j holds a * b[j] shifted by j; columns below N-1 are not built.
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar col = 0; col < W; col++) begin : g_col
            localparam int I = col - j;
            if (I >= 0 && I < N && col >= N - 1) begin : g_bit
                if ((I == N - 1) != (j == N - 1)) begin : g_inv
                    assign pp[j][col] = ~(a_in[I] & b_in[j]);
                end else begin : g_pos
                    assign pp[j][col] = a_in[I] & b_in[j];
                end
            end else begin : g_zero
                assign pp[j][col] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sfc_comp4.sv
module sfc_comp4
    import sfc_mult_pkg::*;
(
    input  logic     x0,
    input  logic     x1,
    input  logic     x2,
    output sfc_out_t y
);
    logic [2:0] lhs, rhs;

    always_comb begin
        // total = n + 1, n in 0..3: parity inverted, floor(total/2) = (n>=1)+(n>=3)
        y.sum    = ~(x0 ^ x1 ^ x2);
        y.carry1 = x0 | x1 | x2;
        y.carry2 = x0 & x1 & x2;
        lhs = {2'b00, y.sum} + {1'b0, y.carry1, 1'b0} + {1'b0, y.carry2, 1'b0};
        rhs = {2'b00, x0} + {2'b00, x1} + {2'b00, x2} + 3'd1;
        a_r3_comp4_count: assert (lhs == rhs)
            else $error("R3 compressor count %0d expected %0d", lhs, rhs);
    end
endmodule

// File: rtl/sfc_comp5.sv
module sfc_comp5
    import sfc_mult_pkg::*;
(
    input  logic     x0,
    input  logic     x1,
    input  logic     x2,
    input  logic     x3,
    output sfc_out_t y
);
    logic [2:0] lhs, rhs;

    always_comb begin
        // total = n + 1, n in 0..4
        y.sum    = ~(x0 ^ x1 ^ x2 ^ x3);
        y.carry1 = x0 | x1 | x2 | x3;
        y.carry2 = (x0 & x1 & (x2 | x3)) | (x2 & x3 & (x0 | x1));
        lhs = {2'b00, y.sum} + {1'b0, y.carry1, 1'b0} + {1'b0, y.carry2, 1'b0};
        rhs = {2'b00, x0} + {2'b00, x1} + {2'b00, x2} + {2'b00, x3} + 3'd1;
        a_r4_comp5_count: assert (lhs == rhs)
            else $error("R4 compressor count %0d expected %0d", lhs, rhs);
    end
endmodule

// File: rtl/sfc_csa_row.sv
module sfc_csa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] z_in,
    output logic [W-1:0] s_out,
    output logic [W-1:0] c_out
);
    logic [W-1:0] maj;

    always_comb begin
        s_out = x_in ^ y_in ^ z_in;
        maj   = (x_in & y_in) | (x_in & z_in) | (y_in & z_in);
        c_out = {maj[W-2:0], 1'b0};
        a_r5_csa_conserve: assert (s_out + c_out == x_in + y_in + z_in)
            else $error("R5 carry-save row lost weight");
    end
endmodule

// File: rtl/sfc_cpa.sv
module sfc_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] sum_out
);
    logic cy;

    always_comb begin
        cy = 1'b0;
        for (int i = 0; i < W; i++) begin
            sum_out[i] = x_in[i] ^ y_in[i] ^ cy;
            cy         = (x_in[i] & y_in[i]) | (cy & (x_in[i] ^ y_in[i]));
        end
        a_r5_cpa_total: assert (sum_out == x_in + y_in)
            else $error("R5 final adder mismatch");
    end
endmodule

// File: rtl/sfc_mult.sv
module sfc_mult
    import sfc_mult_pkg::*;
#(
    parameter int N = 8
) (
    input  logic signed [N-1:0]   op_a,
    input  logic signed [N-1:0]   op_b,
    output logic signed [2*N-1:0] prod
);
    localparam int W    = 2 * N;
    localparam int C    = comp_units(N);      // supported range gives 1 or 2
    localparam int NCMP = (C >= 2) ? 3 : 2;
    localparam int NROW = N + 2 * NCMP + 1;
    localparam int NSTG = NROW - 2;

    logic [N-1:0][W-1:0]    pp;
    logic [N-1:0][W-1:0]    kept;
    logic [NROW-1:0][W-1:0] heap;
    sfc_out_t               o_lo, o_mid, o_extra;

    sfc_ppgen #(.N(N)) u_ppgen (.a_in(op_a), .b_in(op_b), .pp(pp));

    // Column N-1: first compensation one absorbed with four bits.
    sfc_comp5 u_cmp_lo (
        .x0(pp[0][N-1]), .x1(pp[1][N-1]), .x2(pp[2][N-1]), .x3(pp[3][N-1]),
        .y(o_lo)
    );

    // Column N: sign-correction one absorbed with three bits.
    sfc_comp4 u_cmp_mid (
        .x0(pp[1][N]), .x1(pp[2][N]), .x2(pp[3][N]), .y(o_mid)
    );

    // Column N-1: second compensation one, present when C is 2.
    if (C >= 2) begin : g_extra
        sfc_comp4 u_cmp_extra (
            .x0(pp[4][N-1]), .x1(pp[5][N-1]), .x2(pp[6][N-1]), .y(o_extra)
        );
    end else begin : g_no_extra
        assign o_extra = '0;
    end

    always_comb begin
        kept = pp;
        kept[0][N-1] = 1'b0;
        kept[1][N-1] = 1'b0;
        kept[2][N-1] = 1'b0;
        kept[3][N-1] = 1'b0;
        kept[1][N]   = 1'b0;
        kept[2][N]   = 1'b0;
        kept[3][N]   = 1'b0;
        if (C >= 2) begin
            kept[4][N-1] = 1'b0;
            kept[5][N-1] = 1'b0;
            kept[6][N-1] = 1'b0;
        end
    end

    always_comb begin
        heap = '0;
        for (int j = 0; j < N; j++) heap[j] = kept[j];
        heap[N][N-1]   = o_lo.sum;
        heap[N][N]     = o_lo.carry1;
        heap[N+1][N]   = o_lo.carry2;
        heap[N+2][N]   = o_mid.sum;
        heap[N+2][N+1] = o_mid.carry1;
        heap[N+3][N+1] = o_mid.carry2;
        if (C >= 2) begin
            heap[N+4][N-1] = o_extra.sum;
            heap[N+4][N]   = o_extra.carry1;
            heap[N+5][N]   = o_extra.carry2;
        end
        heap[NROW-1][W-1] = 1'b1;   // top sign-correction one, no bits beside it
    end

    logic [W-1:0] acc_s [NSTG];
    logic [W-1:0] acc_c [NSTG];

    for (genvar k = 0; k < NSTG; k++) begin : g_csa
        if (k == 0) begin : g_first
            sfc_csa_row #(.W(W)) u_csa (
                .x_in(heap[0]), .y_in(heap[1]), .z_in(heap[2]),
                .s_out(acc_s[0]), .c_out(acc_c[0])
            );
        end else begin : g_next
            sfc_csa_row #(.W(W)) u_csa (
                .x_in(acc_s[k-1]), .y_in(acc_c[k-1]), .z_in(heap[k+2]),
                .s_out(acc_s[k]), .c_out(acc_c[k])
            );
        end
    end

    logic [W-1:0] total;

    sfc_cpa #(.W(W)) u_cpa (
        .x_in(acc_s[NSTG-1]), .y_in(acc_c[NSTG-1]), .sum_out(total)
    );

    assign prod = total;
endmodule

// File: tb/sfc_mult_bench.sv
module sfc_mult_bench;
    import sfc_mult_pkg::*;

    localparam int N = 8;
    localparam int W = 2 * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic signed [N-1:0] a_drv = '0;
    logic signed [N-1:0] b_drv = '0;
    logic signed [W-1:0] p;

    sfc_mult #(.N(N)) u_sfc_mult (.op_a(a_drv), .op_b(b_drv), .prod(p));

    logic     x0 = 1'b0, x1 = 1'b0, x2 = 1'b0, x3 = 1'b0;
    sfc_out_t y4, y5;
    sfc_comp4 u_c4 (.x0(x0), .x1(x1), .x2(x2), .y(y4));
    sfc_comp5 u_c5 (.x0(x0), .x1(x1), .x2(x2), .x3(x3), .y(y5));

    int    checks = 0;
    int    errors = 0;
    int    npairs = 0;
    real   err_sum = 0.0;
    int    worst = 0;
    bit    done = 1'b0;

    function automatic int offset_k();
        real m = 0.0;
        for (int k = 0; k <= N - 2; k++) m += real'((k + 1) * (1 << k)) / 4.0;
        return $rtoi(m / real'(1 << (N - 1)) + 0.5) * (1 << (N - 1));
    endfunction

    function automatic int dropped(input logic [N-1:0] x, input logic [N-1:0] y);
        int t = 0;
        for (int i = 0; i < N - 1; i++)
            for (int j = 0; j < N - 1; j++)
                if (i + j <= N - 2 && x[i] && y[j]) t += (1 << (i + j));
        return t;
    endfunction

    function automatic int err_bound();
        int tmax = (N - 2) * (1 << (N - 1)) + 1;
        int k = offset_k();
        return (k > tmax - k) ? k : tmax - k;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input bit stats);
        int sx, sy, exact, got, expv, e;
        @(posedge clk);
        a_drv = x;
        b_drv = y;
        @(negedge clk);
        sx = $signed(x);
        sy = $signed(y);
        exact = sx * sy;
        got = p;
        expv = exact - dropped(x, y) + offset_k();
        check(got == expv, "R5 truncate+compensate", got, expv);
        check(p[N-2:0] == '0, "R2 low bits zero", int'(p[N-2:0]), 0);
        e = got - exact;
        check((e < 0 ? -e : e) <= err_bound(), "R6 error bound", e, err_bound());
        if (stats) begin
            npairs++;
            err_sum += real'(e);
            if ((e < 0 ? -e : e) > (worst < 0 ? -worst : worst)) worst = e;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: zero operands after reset give the compensation value alone
        check(int'(p) == offset_k(), "R7 zero operands", int'(p), offset_k());

        // R3 / R4: exhaustive compressor counts
        for (int v = 0; v < 16; v++) begin
            int cnt, w4, w5;
            @(posedge clk);
            {x3, x2, x1, x0} = 4'(v);
            @(negedge clk);
            cnt = int'(x0) + int'(x1) + int'(x2);
            w4 = int'(y4.sum) + 2 * (int'(y4.carry1) + int'(y4.carry2));
            w5 = int'(y5.sum) + 2 * (int'(y5.carry1) + int'(y5.carry2));
            if (v < 8) check(w4 == cnt + 1, "R3 comp4 count", w4, cnt + 1);
            check(w5 == cnt + int'(x3) + 1, "R4 comp5 count", w5, cnt + int'(x3) + 1);
        end

        // R1: extreme signs
        apply(8'h80, 8'h80, 1'b0);
        check(int'(p) == 16640, "R1 min*min", int'(p), 16640);
        apply(8'h80, 8'h7F, 1'b0);
        check(int'(p) == -16000, "R1 min*max", int'(p), -16000);
        // R6: worst-case error pair
        apply(8'h7F, 8'h7F, 1'b0);
        check(int'(p) == 15616, "R6 worst pair", int'(p), 15616);
        apply(8'hFF, 8'hFF, 1'b0);
        apply(8'h01, 8'hFF, 1'b0);

        // random mix with fixed seed
        void'($urandom(32'd2024));
        for (int r = 0; r < 500; r++) apply(8'($urandom), 8'($urandom), 1'b0);

        // exhaustive sweep with error statistics (R5, R6)
        for (int ia = 0; ia < 256; ia++)
            for (int ib = 0; ib < 256; ib++)
                apply(8'(ia), 8'(ib), 1'b1);

        check(worst == -err_bound(), "R6 worst error reached", worst, -err_bound());
        $display("mean error %f worst error %0d over %0d pairs",
                 err_sum / real'(npairs), worst, npairs);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule